// File: doc/BRIEF.md
# Privileged Trap and Status Control Unit

This unit sits beside a simple in-order processor and turns reported exception conditions into a transfer of control to the operating system. Each cycle it looks at the exception request lines coming from the datapath, together with one illegal-instruction condition that it raises itself. If at least one request is enabled by the mask register, the unit picks one cause. It then saves the program counter of the interrupted instruction and the cause code. On an address error it also saves the faulting virtual address. Finally it redirects the next fetch to a fixed handler entry point and enters privileged mode.

The unit also carries out three privileged operations that the decoder reports as one-cycle strobes. The first copies one of the unit's numbered registers onto the read-data output. The second writes the value on the write-data input into a numbered register. The third returns the processor to user mode. If any of these strobes arrives while the processor is in user mode, the operation is not performed and an illegal-instruction exception is raised in its place. A system-call instruction is reported on its own request line and goes through the same path as hardware faults.

Top module: `cop_trap_unit`

## Requirements
- R1: After reset the processor is in privileged mode, `pcOverride` is 0, the mask register (number 12) reads 0x0000_1511, and registers 8, 13 and 14 read 0.
- R2: An enabled request in cycle N sets `pcOverride` to 1 in cycle N+1, with `pcTarget` = 0x8000_0080 and `privMode` = 1. When no request is taken, `pcOverride` is 0 and `pcTarget` is 0.
- R3: On a taken exception, register 14 captures the `curPc` value of the cycle in which the request was seen.
- R4: Request line bit 0 is interrupt (code 0), bit 1 is address error (code 4), bit 2 is syscall (code 8) and bit 3 is overflow (code 12). A user-mode privileged strobe is code 10. When several enabled requests are present together, register 13 records the lowest code.
- R5: Register 8 loads `faultAddr` only when the recorded cause is address error (code 4). Every other cause leaves it unchanged.
- R6: Bit n of the mask register enables cause code n. A request whose bit is 0 is ignored: no redirect and no change to any register or to the privilege state.
- R7: A move-from strobe in privileged mode drives `rdData` with the selected register in the same cycle, zero-extended. Register numbers other than 8, 12, 13 and 14 read 0. Without a privileged move-from, `rdData` is 0.
- R8: A move-to strobe in privileged mode writes `wrData` into register 8, 12, 13 or 14 at the next clock edge. Register 13 keeps only its low 5 bits.
- R9: A move-from, move-to or return strobe in user mode performs no read, write or mode change. It raises cause 10, subject to the mask.
- R10: A return strobe in privileged mode clears `privMode` at the next edge and does not redirect the PC.
- R11: A syscall request is taken through the same path as the hardware requests, records code 8 and enters privileged mode.
- R12: When an exception is taken in the same cycle as a privileged move-to or return, the write and the mode change are suppressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| excReq | input | 4 | Exception requests: interrupt, address error, syscall, overflow (bits 0..3) |
| curPc | input | 32 | PC of the instruction in the current cycle |
| faultAddr | input | 32 | Virtual address of a faulting access |
| mfcStb | input | 1 | Move-from-coprocessor strobe |
| mtcStb | input | 1 | Move-to-coprocessor strobe |
| rfeStb | input | 1 | Return-from-exception strobe |
| regSel | input | 5 | Coprocessor register number for move operations |
| wrData | input | 32 | Data for move-to |
| rdData | output | 32 | Data for move-from |
| pcOverride | output | 1 | Next PC must be taken from `pcTarget` |
| pcTarget | output | 32 | Handler address while `pcOverride` is high |
| privMode | output | 1 | 1 = privileged, 0 = user |

## Verification
The assertions check several properties on every cycle. A redirect always points at the handler and comes with privileged mode. Privileged mode is only entered through a redirect and only left after a return strobe. `rdData` stays zero in user mode and whenever no move-from is requested. Some behaviours can only be shown by the bench's scenarios, because they depend on register contents that are observed through later move-from reads. These are the cause priority among simultaneous requests, the contents saved into registers 8, 13 and 14, mask gating, and suppression of a move-to that coincides with an exception.

// File: rtl/cop_trap_pkg.sv
package cop_trap_pkg;
  localparam int NUM_EXT = 4;
  localparam int NUM_SRC = NUM_EXT + 1;
  localparam int CODE_W  = 5;
  localparam int SEL_W   = 5;

  // source index order follows ascending cause code (priority order)
  localparam int SRC_INT  = 0;
  localparam int SRC_ADDR = 1;
  localparam int SRC_SYS  = 2;
  localparam int SRC_ILL  = 3;
  localparam int SRC_OVF  = 4;

  localparam logic [SEL_W-1:0] REG_BADADDR = 5'd8;
  localparam logic [SEL_W-1:0] REG_MASK    = 5'd12;
  localparam logic [SEL_W-1:0] REG_CAUSE   = 5'd13;
  localparam logic [SEL_W-1:0] REG_EPC     = 5'd14;

  function automatic logic [CODE_W-1:0] srcCode(input int idx);
    case (idx)
      SRC_INT:  return 5'd0;
      SRC_ADDR: return 5'd4;
      SRC_SYS:  return 5'd8;
      SRC_ILL:  return 5'd10;
      default:  return 5'd12;
    endcase
  endfunction

  typedef struct packed {
    logic              take;
    logic [CODE_W-1:0] code;
    logic              saveBad;
    logic              wrEn;
    logic              clrPriv;
  } ctlStrobe_t;
endpackage

// File: rtl/cop_trap_ctrl.sv
module cop_trap_ctrl
  import cop_trap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [NUM_EXT-1:0] excReq,
  input  logic [DATA_W-1:0]  maskQ,
  input  logic               privQ,
  input  logic               mfcStb,
  input  logic               mtcStb,
  input  logic               rfeStb,
  output ctlStrobe_t         stb
);
  logic               illegalOp;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] enabled;

  assign illegalOp = !privQ && (mfcStb || mtcStb || rfeStb);
  assign pend      = {excReq[NUM_EXT-1], illegalOp, excReq[NUM_EXT-2:0]};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_en
    assign enabled[g] = pend[g] && maskQ[srcCode(g)];
  end

  always_comb begin
    stb = '0;
    // scan downwards so the lowest code is the last one assigned
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (enabled[i]) begin
        stb.take = 1'b1;
        stb.code = srcCode(i);
      end
    end
    stb.saveBad = stb.take && (stb.code == srcCode(SRC_ADDR));
    stb.wrEn    = !stb.take && privQ && mtcStb;
    stb.clrPriv = !stb.take && privQ && rfeStb;
  end
endmodule

// File: rtl/cop_trap_regs.sv
module cop_trap_regs
  import cop_trap_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter logic [31:0]     HANDLER    = 32'h8000_0080,
  parameter logic [31:0]     RESET_MASK = 32'h0000_1511
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] faultAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              mfcStb,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] maskQ,
  output logic              privQ,
  output logic              ovrQ,
  output logic [DATA_W-1:0] pcTarget
);
  logic [DATA_W-1:0] epcQ;
  logic [DATA_W-1:0] badQ;
  logic [CODE_W-1:0] causeQ;
  logic [DATA_W-1:0] selVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      epcQ   <= '0;
      badQ   <= '0;
      causeQ <= '0;
      maskQ  <= RESET_MASK[DATA_W-1:0];
      privQ  <= 1'b1;
      ovrQ   <= 1'b0;
    end else begin
      ovrQ <= stb.take;
      if (stb.take) begin
        epcQ   <= curPc;
        causeQ <= stb.code;
        privQ  <= 1'b1;
        if (stb.saveBad) badQ <= faultAddr;
      end else begin
        if (stb.wrEn) begin
          case (regSel)
            REG_BADADDR: badQ   <= wrData;
            REG_MASK:    maskQ  <= wrData;
            REG_CAUSE:   causeQ <= wrData[CODE_W-1:0];
            REG_EPC:     epcQ   <= wrData;
            default: ;
          endcase
        end
        if (stb.clrPriv) privQ <= 1'b0;
      end
    end
  end

  always_comb begin
    case (regSel)
      REG_BADADDR: selVal = badQ;
      REG_MASK:    selVal = maskQ;
      REG_CAUSE:   selVal = {{(DATA_W-CODE_W){1'b0}}, causeQ};
      REG_EPC:     selVal = epcQ;
      default:     selVal = '0;
    endcase
  end

  assign rdData   = (mfcStb && privQ) ? selVal : '0;
  assign pcTarget = ovrQ ? HANDLER[DATA_W-1:0] : '0;
endmodule

// File: rtl/cop_trap_unit.sv
module cop_trap_unit
  import cop_trap_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] HANDLER    = 32'h8000_0080,
  parameter logic [31:0] RESET_MASK = 32'h0000_1511
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        excReq,
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] faultAddr,
  input  logic              mfcStb,
  input  logic              mtcStb,
  input  logic              rfeStb,
  input  logic [4:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              pcOverride,
  output logic [DATA_W-1:0] pcTarget,
  output logic              privMode
);
  ctlStrobe_t        stb;
  logic [DATA_W-1:0] maskQ;
  logic              privQ;

  cop_trap_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .excReq(excReq), .maskQ(maskQ), .privQ(privQ),
    .mfcStb(mfcStb), .mtcStb(mtcStb), .rfeStb(rfeStb), .stb(stb)
  );

  cop_trap_regs #(.DATA_W(DATA_W), .HANDLER(HANDLER), .RESET_MASK(RESET_MASK)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .curPc(curPc), .faultAddr(faultAddr),
    .wrData(wrData), .regSel(regSel), .mfcStb(mfcStb), .rdData(rdData),
    .maskQ(maskQ), .privQ(privQ), .ovrQ(pcOverride), .pcTarget(pcTarget)
  );

  assign privMode = privQ;
endmodule

// File: rtl/cop_trap_checker.sv
module cop_trap_checker #(
  parameter int          DATA_W  = 32,
  parameter logic [31:0] HANDLER = 32'h8000_0080
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        excReq,
  input logic              mfcStb,
  input logic              mtcStb,
  input logic              rfeStb,
  input logic [DATA_W-1:0] rdData,
  input logic              pcOverride,
  input logic [DATA_W-1:0] pcTarget,
  input logic              privMode
);
  p_target_r2: assert property (@(posedge clk) disable iff (!rstN)
    pcOverride |-> (pcTarget == HANDLER[DATA_W-1:0] && privMode));

  p_priv_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(privMode) |-> pcOverride);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rstN)
    (excReq == 4'd0 && !mfcStb && !mtcStb && !rfeStb) |=> !pcOverride);

  p_priv_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(privMode) |-> $past(rfeStb));

  p_user_read_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !privMode |-> rdData == '0);

  p_idle_read_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !mfcStb |-> rdData == '0);
endmodule

bind cop_trap_unit cop_trap_checker #(.DATA_W(DATA_W), .HANDLER(HANDLER)) u_chk (
  .clk(clk), .rstN(rstN), .excReq(excReq), .mfcStb(mfcStb), .mtcStb(mtcStb),
  .rfeStb(rfeStb), .rdData(rdData), .pcOverride(pcOverride), .pcTarget(pcTarget),
  .privMode(privMode)
);

// File: tb/cop_trap_unit_bench.sv
module cop_trap_unit_bench;
  localparam logic [31:0] HANDLER = 32'h8000_0080;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  excReq = '0;
  logic [31:0] curPc = '0, faultAddr = '0, wrData = '0;
  logic        mfcStb = 1'b0, mtcStb = 1'b0, rfeStb = 1'b0;
  logic [4:0]  regSel = '0;
  logic [31:0] rdData, pcTarget;
  logic        pcOverride, privMode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] mEpc, mBad, mMask;
  logic [4:0]  mCause;
  logic        mPriv, mOvr;

  always #5 clk = ~clk;

  cop_trap_unit u_cop_trap_unit (
    .clk(clk), .rstN(rstN), .excReq(excReq), .curPc(curPc), .faultAddr(faultAddr),
    .mfcStb(mfcStb), .mtcStb(mtcStb), .rfeStb(rfeStb), .regSel(regSel), .wrData(wrData),
    .rdData(rdData), .pcOverride(pcOverride), .pcTarget(pcTarget), .privMode(privMode)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [4:0] sel);
    case (sel)
      5'd8:    return mBad;
      5'd12:   return mMask;
      5'd13:   return {27'd0, mCause};
      5'd14:   return mEpc;
      default: return 32'd0;
    endcase
  endfunction

  // R4: lowest enabled code wins; returns 31 when nothing is taken
  function automatic logic [4:0] modelCode(input logic [3:0] rq, input logic ill);
    logic [4:0] codes [5];
    logic       pend  [5];
    codes = '{5'd0, 5'd4, 5'd8, 5'd10, 5'd12};
    pend  = '{rq[0], rq[1], rq[2], ill, rq[3]};
    for (int i = 0; i < 5; i++)
      if (pend[i] && mMask[codes[i]]) return codes[i];
    return 5'd31;
  endfunction

  task automatic step(input string tag, input logic [3:0] rq, input logic mf, input logic mt,
                      input logic rf, input logic [4:0] sel, input logic [31:0] wd,
                      input logic [31:0] pc, input logic [31:0] fa);
    logic [4:0] code;
    logic       ill;
    excReq = rq; mfcStb = mf; mtcStb = mt; rfeStb = rf;
    regSel = sel; wrData = wd; curPc = pc; faultAddr = fa;
    #1;
    chk(tag, "rdData", rdData, (mf && mPriv) ? modelRead(sel) : 32'd0);
    ill  = !mPriv && (mf || mt || rf);
    code = modelCode(rq, ill);
    if (code != 5'd31) begin
      mOvr = 1'b1; mEpc = pc; mCause = code; mPriv = 1'b1;
      if (code == 5'd4) mBad = fa;
    end else begin
      mOvr = 1'b0;
      if (mPriv && mt) begin
        case (sel)
          5'd8:  mBad = wd;
          5'd12: mMask = wd;
          5'd13: mCause = wd[4:0];
          5'd14: mEpc = wd;
          default: ;
        endcase
      end
      if (mPriv && rf) mPriv = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "pcOverride", {31'd0, pcOverride}, {31'd0, mOvr});
    chk(tag, "privMode", {31'd0, privMode}, {31'd0, mPriv});
    chk(tag, "pcTarget", pcTarget, mOvr ? HANDLER : 32'd0);
  endtask

  task automatic rd(input string tag, input logic [4:0] sel);
    step(tag, 4'd0, 1'b1, 1'b0, 1'b0, sel, 32'd0, 32'h100, 32'd0);
  endtask

  initial begin
    mEpc = '0; mBad = '0; mMask = 32'h0000_1511; mCause = '0; mPriv = 1'b1; mOvr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "reset pcOverride", {31'd0, pcOverride}, 32'd0);
    chk("R1", "reset privMode", {31'd0, privMode}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    rd("R1 mask", 5'd12); rd("R1 cause", 5'd13); rd("R1 epc", 5'd14); rd("R1 bad", 5'd8);
    rd("R7 unmapped", 5'd3);
    // R2 R3 R5: address error
    step("R2 addr err", 4'b0010, 0, 0, 0, 5'd0, 0, 32'h0000_0400, 32'hDEAD_BEE0);
    rd("R3 epc", 5'd14); rd("R4 cause4", 5'd13); rd("R5 bad", 5'd8);
    // R11: syscall, R5 keeps bad address
    step("R11 syscall", 4'b0100, 0, 0, 0, 5'd0, 0, 32'h0000_0500, 32'h1111_1111);
    rd("R11 cause8", 5'd13); rd("R5 bad kept", 5'd8);
    // R4: simultaneous requests
    step("R4 multi", 4'b1110, 0, 0, 0, 5'd0, 0, 32'h0000_0600, 32'h2222_2220);
    rd("R4 cause", 5'd13);
    step("R4 int+ovf", 4'b1001, 0, 0, 0, 5'd0, 0, 32'h0000_0700, 32'd0);
    rd("R4 cause0", 5'd13);
    // R6 R8: mask only overflow
    step("R8 write mask", 4'd0, 0, 1, 0, 5'd12, 32'h0000_1000, 32'h0000_0800, 32'd0);
    rd("R8 mask", 5'd12);
    step("R6 masked int", 4'b0001, 0, 0, 0, 5'd0, 0, 32'h0000_0900, 32'd0);
    rd("R6 epc kept", 5'd14); rd("R6 cause kept", 5'd13);
    step("R6 ovf", 4'b1000, 0, 0, 0, 5'd0, 0, 32'h0000_0A00, 32'd0);
    rd("R6 cause12", 5'd13);
    step("R8 restore mask", 4'd0, 0, 1, 0, 5'd12, 32'h0000_1511, 32'h0000_0B00, 32'd0);
    step("R8 write cause", 4'd0, 0, 1, 0, 5'd13, 32'hFFFF_FFE3, 32'h0000_0B04, 32'd0);
    rd("R8 cause trunc", 5'd13);
    // R10 then R9
    step("R10 rfe", 4'd0, 0, 0, 1, 5'd0, 0, 32'h0000_0C00, 32'd0);
    step("R9 user mfc", 4'd0, 1, 0, 0, 5'd14, 0, 32'h0000_0C04, 32'd0);
    rd("R9 cause10", 5'd13);
    step("R10 rfe", 4'd0, 0, 0, 1, 5'd0, 0, 32'h0000_0D00, 32'd0);
    step("R9 user mtc", 4'd0, 0, 1, 0, 5'd8, 32'h0000_0123, 32'h0000_0D04, 32'd0);
    rd("R9 bad kept", 5'd8); rd("R9 epc", 5'd14);
    // R12: exception beats mtc/rfe
    step("R12 exc+mtc", 4'b0001, 0, 1, 0, 5'd8, 32'h0000_0005, 32'h0000_0E00, 32'd0);
    rd("R12 bad kept", 5'd8);
    step("R12 exc+rfe", 4'b1000, 0, 0, 1, 5'd0, 0, 32'h0000_0E04, 32'd0);
    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic [3:0]  rq;
      logic [4:0]  sel;
      logic [31:0] wd;
      int          k;
      logic [4:0]  sels [5];
      sels = '{5'd8, 5'd12, 5'd13, 5'd14, 5'd2};
      rq  = ($urandom % 4 == 0) ? 4'($urandom) : 4'd0;
      sel = sels[$urandom % 5];
      wd  = (sel == 5'd12) ? ($urandom | 32'h0000_0400) : $urandom;
      k   = $urandom % 6;
      step("R2 R3 R4 R6 R8 random", rq, k == 0 || k == 3, k == 1, k == 2,
           sel, wd, $urandom & 32'hFFFF_FFFC, $urandom);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule